// File: doc/BRIEF.md
# Half-Precision Compare Unit

This block compares two binary16 floating-point operands and returns a lane mask of all ones (true) or all zeros (false), as a SIMD compare instruction writes to its destination lane. A 5-bit function code picks one of five relations. Equality compares signed values. Greater-or-equal and greater-than each come in a signed form and a magnitude form, where the sign bits of both operands are dropped first. Each operation handles NaN operands in one of two ways. Equality is a quiet compare and flags only signaling NaNs. The ordered relations are signaling compares and flag every NaN.

The result is registered, so it appears one cycle after the input valid strobe. An invalid-operation event sets a sticky flag. The flag is held by a two-state machine: FLAG_CLEAN and FLAG_RAISED. Transition *raise* goes from FLAG_CLEAN to FLAG_RAISED on any accepted compare that signals invalid. Transition *clear* goes from FLAG_RAISED to FLAG_CLEAN when the clear input is high and no invalid event arrives in the same cycle. Transition *hold* keeps the current state in every other case, and a new event wins over a simultaneous clear. A function code outside the five known codes produces a zero mask and a one-cycle unsupported-code strobe, and leaves the flag alone.

Top module: `hcmp_unit`

## Requirements
- R1: A completed compare drives `mask` to all ones when true and all zeros when false. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high.
- R2: These function codes select the operations: 5'h04 equal, 5'h14 greater-or-equal, 5'h15 magnitude greater-or-equal, 5'h1C greater-than, 5'h1D magnitude greater-than.
- R3: Equality with a quiet NaN operand gives false and does not raise invalid. A quiet NaN has exponent all ones and mantissa bit 9 set.
- R4: A signaling NaN operand raises invalid even in the equality compare. A signaling NaN has exponent all ones, mantissa bit 9 clear and a non-zero mantissa.
- R5: For the four ordered relations, any NaN operand gives false and raises invalid.
- R6: The magnitude variants ignore both sign bits before comparing.
- R7: Positive and negative zero compare equal, and neither is greater than the other.
- R8: Subnormal operands are compared exactly, with no flush to zero.
- R9: `invalid_sticky` stays high until `clr_invalid` is high in a cycle with no new invalid event. A new event in the same cycle as a clear leaves it high.
- R10: Any other function code gives a zero mask with `bad_code` high for that one result cycle, and the invalid flag is unchanged.
- R11: During reset, `out_valid`, `mask`, `invalid_sticky` and `bad_code` are all zero.
- R12: A cycle with `in_valid` low gives `out_valid` low, a zero mask, and no change to `invalid_sticky` unless a clear is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and code are presented |
| op_a | input | 16 | First binary16 operand |
| op_b | input | 16 | Second binary16 operand |
| func | input | 5 | Compare function code |
| clr_invalid | input | 1 | Clears the sticky invalid flag |
| out_valid | output | 1 | Result present this cycle |
| mask | output | MASK_W | Lane mask, all ones or all zeros |
| invalid_sticky | output | 1 | Sticky invalid-operation flag |
| bad_code | output | 1 | Unsupported function code strobe |

## Verification
The bench builds the unit with `MASK_W` set to 32. That width is twice the operand width, so a mask built from too few bits, or one that replicates the wrong value, shows up in the upper half of the word. Operand values are fixed in pairs chosen to sit on the corners of the ordering. These include the two signed zeros, subnormal neighbours, the step from the largest subnormal to the smallest normal, infinity against the largest finite value, and quiet and signaling NaNs carrying either sign.

// File: rtl/hcmp_pkg.sv
package hcmp_pkg;

    localparam int EXP_W = 5;
    localparam int MAN_W = 10;
    localparam int HW    = 1 + EXP_W + MAN_W;
    localparam int MAG_W = HW - 1;

    localparam logic [4:0] FC_EQ  = 5'h04;
    localparam logic [4:0] FC_GE  = 5'h14;
    localparam logic [4:0] FC_AGE = 5'h15;
    localparam logic [4:0] FC_GT  = 5'h1C;
    localparam logic [4:0] FC_AGT = 5'h1D;

    typedef enum logic [2:0] {
        OP_EQ,
        OP_GE,
        OP_GT,
        OP_AGE,
        OP_AGT,
        OP_NONE
    } cmp_op_e;

    typedef enum logic {
        FLAG_CLEAN,
        FLAG_RAISED
    } flag_state_e;

    typedef struct packed {
        logic             is_nan;
        logic             is_snan;
        logic             is_zero;
        logic             sign;
        logic [MAG_W-1:0] mag;
    } opnd_t;

endpackage

// File: rtl/hcmp_decode.sv
module hcmp_decode
    import hcmp_pkg::*;
(
    input  logic [4:0] func,
    output logic       known,
    output logic       use_abs,
    output logic       signaling,
    output logic       want_eq,
    output logic       want_gt
);

    cmp_op_e op;

    always_comb begin
        case (func)
            FC_EQ:   op = OP_EQ;
            FC_GE:   op = OP_GE;
            FC_AGE:  op = OP_AGE;
            FC_GT:   op = OP_GT;
            FC_AGT:  op = OP_AGT;
            default: op = OP_NONE;
        endcase
    end

    always_comb begin
        known     = 1'b1;
        use_abs   = 1'b0;
        signaling = 1'b1;
        want_eq   = 1'b0;
        want_gt   = 1'b0;
        unique case (op)
            OP_EQ: begin
                signaling = 1'b0;
                want_eq   = 1'b1;
            end
            OP_GE: begin
                want_eq = 1'b1;
                want_gt = 1'b1;
            end
            OP_GT: begin
                want_gt = 1'b1;
            end
            OP_AGE: begin
                use_abs = 1'b1;
                want_eq = 1'b1;
                want_gt = 1'b1;
            end
            OP_AGT: begin
                use_abs = 1'b1;
                want_gt = 1'b1;
            end
            default: begin
                known     = 1'b0;
                signaling = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hcmp_classify.sv
module hcmp_classify
    import hcmp_pkg::*;
(
    input  logic [HW-1:0] raw,
    input  logic          clear_sign,
    output opnd_t         info
);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_max;
    logic             man_nz;

    always_comb begin
        exp_f   = raw[HW-2 -: EXP_W];
        man_f   = raw[MAN_W-1:0];
        exp_max = &exp_f;
        man_nz  = |man_f;

        info.sign    = raw[HW-1] & ~clear_sign;
        info.mag     = raw[MAG_W-1:0];
        info.is_nan  = exp_max & man_nz;
        info.is_snan = exp_max & man_nz & ~man_f[MAN_W-1];
        info.is_zero = ~|raw[MAG_W-1:0];
    end

endmodule

// File: rtl/hcmp_relate.sv
module hcmp_relate
    import hcmp_pkg::*;
(
    input  opnd_t lhs,
    input  opnd_t rhs,
    output logic  unordered,
    output logic  equal,
    output logic  greater
);

    logic [HW-1:0] key_l;
    logic [HW-1:0] key_r;

    function automatic logic [HW-1:0] order_key(input opnd_t v);
        logic [HW-1:0] k;
        if (v.is_zero)
            k = {1'b1, {MAG_W{1'b0}}};
        else if (v.sign)
            k = {1'b0, ~v.mag};
        else
            k = {1'b1, v.mag};
        return k;
    endfunction

    always_comb begin
        key_l     = order_key(lhs);
        key_r     = order_key(rhs);
        unordered = lhs.is_nan | rhs.is_nan;
        equal     = ~unordered & (key_l == key_r);
        greater   = ~unordered & (key_l > key_r);
    end

endmodule

// File: rtl/hcmp_unit.sv
module hcmp_unit
    import hcmp_pkg::*;
#(
    parameter int MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       op_a,
    input  logic [15:0]       op_b,
    input  logic [4:0]        func,
    input  logic              clr_invalid,
    output logic              out_valid,
    output logic [MASK_W-1:0] mask,
    output logic              invalid_sticky,
    output logic              bad_code
);

    localparam int N_OPND = 2;

    logic known, use_abs, signaling, want_eq, want_gt;
    logic unordered, rel_eq, rel_gt;
    logic hit, raise;

    logic [HW-1:0] raw_in [N_OPND];
    opnd_t         info   [N_OPND];

    flag_state_e state_q, state_d;

    logic              valid_q;
    logic [MASK_W-1:0] mask_q;
    logic              bad_q;

    hcmp_decode u_decode (
        .func      (func),
        .known     (known),
        .use_abs   (use_abs),
        .signaling (signaling),
        .want_eq   (want_eq),
        .want_gt   (want_gt)
    );

    assign raw_in[0] = op_a;
    assign raw_in[1] = op_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        hcmp_classify u_classify (
            .raw        (raw_in[g]),
            .clear_sign (use_abs),
            .info       (info[g])
        );
    end

    hcmp_relate u_relate (
        .lhs       (info[0]),
        .rhs       (info[1]),
        .unordered (unordered),
        .equal     (rel_eq),
        .greater   (rel_gt)
    );

    always_comb begin
        hit   = known & ~unordered & ((want_eq & rel_eq) | (want_gt & rel_gt));
        raise = in_valid & known &
                (signaling ? (info[0].is_nan  | info[1].is_nan)
                           : (info[0].is_snan | info[1].is_snan));
    end

    // Sticky invalid flag: state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FLAG_CLEAN;
        else
            state_q <= state_d;
    end

    // Sticky invalid flag: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAN: begin
                if (raise)
                    state_d = FLAG_RAISED;
            end
            FLAG_RAISED: begin
                if (clr_invalid && !raise)
                    state_d = FLAG_CLEAN;
            end
        endcase
    end

    // Result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            mask_q  <= '0;
            bad_q   <= 1'b0;
        end else begin
            valid_q <= in_valid;
            mask_q  <= {MASK_W{in_valid & hit}};
            bad_q   <= in_valid & ~known;
        end
    end

    assign out_valid      = valid_q;
    assign mask           = mask_q;
    assign bad_code       = bad_q;
    assign invalid_sticky = (state_q == FLAG_RAISED);

endmodule

// File: rtl/hcmp_checker.sv
module hcmp_checker #(
    parameter int MASK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [15:0]       op_a,
    input logic [15:0]       op_b,
    input logic [4:0]        func,
    input logic              clr_invalid,
    input logic              out_valid,
    input logic [MASK_W-1:0] mask,
    input logic              invalid_sticky,
    input logic              bad_code
);

    logic code_ok, ordered_code, any_nan;

    always_comb begin
        code_ok      = (func == 5'h04) || (func == 5'h14) || (func == 5'h15) ||
                       (func == 5'h1C) || (func == 5'h1D);
        ordered_code = code_ok && (func != 5'h04);
        any_nan      = ((op_a[14:10] == 5'h1F) && (op_a[9:0] != 10'd0)) ||
                       ((op_b[14:10] == 5'h1F) && (op_b[9:0] != 10'd0));
    end

    p_mask_form_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mask == '0 || mask == '1));

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && mask == '0 && !bad_code));

    p_idle_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clr_invalid) |=> $stable(invalid_sticky));

    p_nan_ordered_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ordered_code && any_nan) |=> (mask == '0 && invalid_sticky));

    p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_sticky && !clr_invalid) |=> invalid_sticky);

    p_bad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_code |-> (out_valid && mask == '0));

    p_bad_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !code_ok && !clr_invalid) |=> (bad_code && $stable(invalid_sticky)));

endmodule

bind hcmp_unit hcmp_checker #(.MASK_W(MASK_W)) i_hcmp_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .op_a           (op_a),
    .op_b           (op_b),
    .func           (func),
    .clr_invalid    (clr_invalid),
    .out_valid      (out_valid),
    .mask           (mask),
    .invalid_sticky (invalid_sticky),
    .bad_code       (bad_code)
);

// File: tb/test_hcmp_unit.sv
module test_hcmp_unit;

    localparam int MW = 32;

    localparam logic [4:0] C_EQ = 5'h04, C_GE = 5'h14, C_AGE = 5'h15,
                           C_GT = 5'h1C, C_AGT = 5'h1D;

    localparam logic [15:0] P_ONE = 16'h3C00, P_TWO = 16'h4000,
                            N_ONE = 16'hBC00, N_TWO = 16'hC000,
                            P_ZER = 16'h0000, N_ZER = 16'h8000,
                            QNAN  = 16'h7E00, NQNAN = 16'hFE00,
                            SNAN  = 16'h7C01, P_INF = 16'h7C00,
                            MAXF  = 16'h7BFF;

    localparam logic [MW-1:0] T = '1;
    localparam logic [MW-1:0] F = '0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [15:0]   op_a = '0;
    logic [15:0]   op_b = '0;
    logic [4:0]    func = '0;
    logic          clr_invalid = 1'b0;
    logic          out_valid;
    logic [MW-1:0] mask;
    logic          invalid_sticky;
    logic          bad_code;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hcmp_unit #(.MASK_W(MW)) i_hcmp_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .op_a           (op_a),
        .op_b           (op_b),
        .func           (func),
        .clr_invalid    (clr_invalid),
        .out_valid      (out_valid),
        .mask           (mask),
        .invalid_sticky (invalid_sticky),
        .bad_code       (bad_code)
    );

    task automatic chk(input string req, input string what, input logic [MW-1:0] e_mask,
                       input logic e_val, input logic e_inv, input logic e_bad);
        checks++;
        if (mask !== e_mask || out_valid !== e_val || invalid_sticky !== e_inv || bad_code !== e_bad) begin
            errors++;
            $display("FAIL %s %s: mask=%h valid=%b inv=%b bad=%b expected mask=%h valid=%b inv=%b bad=%b",
                     req, what, mask, out_valid, invalid_sticky, bad_code, e_mask, e_val, e_inv, e_bad);
        end
    endtask

    task automatic run(input logic [4:0] f, input logic [15:0] a, input logic [15:0] b,
                       input logic clr);
        @(negedge clk);
        in_valid    = 1'b1;
        func        = f;
        op_a        = a;
        op_b        = b;
        clr_invalid = clr;
        @(negedge clk);
        in_valid    = 1'b0;
        clr_invalid = 1'b0;
    endtask

    task automatic cmp(input string req, input string what, input logic [4:0] f,
                       input logic [15:0] a, input logic [15:0] b, input logic [MW-1:0] e_mask,
                       input logic e_inv);
        run(f, a, b, 1'b0);
        chk(req, what, e_mask, 1'b1, e_inv, 1'b0);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        clr_invalid = 1'b1;
        @(negedge clk);
        clr_invalid = 1'b0;
    endtask

    task automatic t_reset();
        in_valid = 1'b1;
        func     = C_GE;
        op_a     = P_TWO;
        op_b     = P_ONE;
        repeat (3) @(negedge clk);
        chk("R11", "outputs during reset", F, 1'b0, 1'b0, 1'b0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        chk("R12", "first idle cycle after reset", F, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_codes();
        cmp("R2", "eq 2,1",  C_EQ,  P_TWO, P_ONE, F, 1'b0);
        cmp("R2", "ge 2,1",  C_GE,  P_TWO, P_ONE, T, 1'b0);
        cmp("R2", "gt 2,1",  C_GT,  P_TWO, P_ONE, T, 1'b0);
        cmp("R2", "age 2,1", C_AGE, P_TWO, P_ONE, T, 1'b0);
        cmp("R2", "agt 2,1", C_AGT, P_TWO, P_ONE, T, 1'b0);
        cmp("R1", "eq 1,1",  C_EQ,  P_ONE, P_ONE, T, 1'b0);
        cmp("R1", "ge 1,1",  C_GE,  P_ONE, P_ONE, T, 1'b0);
        cmp("R1", "gt 1,1",  C_GT,  P_ONE, P_ONE, F, 1'b0);
        cmp("R1", "gt -2,-1", C_GT, N_TWO, N_ONE, F, 1'b0);
        cmp("R1", "gt -1,-2", C_GT, N_ONE, N_TWO, T, 1'b0);
        cmp("R1", "gt inf,max", C_GT, P_INF, MAXF, T, 1'b0);
        cmp("R1", "ge max,inf", C_GE, MAXF, P_INF, F, 1'b0);
    endtask

    task automatic t_abs();
        cmp("R6", "ge -2,1",  C_GE,  N_TWO, P_ONE, F, 1'b0);
        cmp("R6", "age -2,1", C_AGE, N_TWO, P_ONE, T, 1'b0);
        cmp("R6", "agt -2,1", C_AGT, N_TWO, P_ONE, T, 1'b0);
        cmp("R6", "agt 1,-2", C_AGT, P_ONE, N_TWO, F, 1'b0);
        cmp("R6", "age -1,1", C_AGE, N_ONE, P_ONE, T, 1'b0);
        cmp("R6", "agt -1,1", C_AGT, N_ONE, P_ONE, F, 1'b0);
    endtask

    task automatic t_zero();
        cmp("R7", "eq +0,-0", C_EQ,  P_ZER, N_ZER, T, 1'b0);
        cmp("R7", "gt +0,-0", C_GT,  P_ZER, N_ZER, F, 1'b0);
        cmp("R7", "gt -0,+0", C_GT,  N_ZER, P_ZER, F, 1'b0);
        cmp("R7", "ge -0,+0", C_GE,  N_ZER, P_ZER, T, 1'b0);
        cmp("R7", "agt -0,+0", C_AGT, N_ZER, P_ZER, F, 1'b0);
    endtask

    task automatic t_subnormal();
        cmp("R8", "gt sub2,sub1",    C_GT, 16'h0002, 16'h0001, T, 1'b0);
        cmp("R8", "eq sub1,sub2",    C_EQ, 16'h0001, 16'h0002, F, 1'b0);
        cmp("R8", "gt sub1,+0",      C_GT, 16'h0001, P_ZER,    T, 1'b0);
        cmp("R8", "ge maxsub,minnorm", C_GE, 16'h03FF, 16'h0400, F, 1'b0);
        cmp("R8", "gt -sub1,-sub2",  C_GT, 16'h8001, 16'h8002, T, 1'b0);
        cmp("R8", "gt -sub1,-0",     C_GT, 16'h8001, N_ZER,    F, 1'b0);
    endtask

    task automatic t_quiet_eq();
        cmp("R3", "eq qnan,1",    C_EQ, QNAN, P_ONE, F, 1'b0);
        cmp("R3", "eq qnan,qnan", C_EQ, QNAN, QNAN,  F, 1'b0);
        cmp("R3", "eq 1,-qnan",   C_EQ, P_ONE, NQNAN, F, 1'b0);
    endtask

    task automatic t_snan_eq();
        cmp("R4", "eq snan,1", C_EQ, SNAN, P_ONE, F, 1'b1);
        clear_flag();
        chk("R9", "flag cleared", F, 1'b0, 1'b0, 1'b0);
        cmp("R4", "eq 1,snan", C_EQ, P_ONE, SNAN, F, 1'b1);
        clear_flag();
    endtask

    task automatic t_signal();
        cmp("R5", "ge qnan,1", C_GE, QNAN, P_ONE, F, 1'b1);
        clear_flag();
        cmp("R5", "gt 1,qnan", C_GT, P_ONE, QNAN, F, 1'b1);
        clear_flag();
        cmp("R5", "agt -qnan,1", C_AGT, NQNAN, P_ONE, F, 1'b1);
        clear_flag();
        cmp("R5", "age snan,snan", C_AGE, SNAN, SNAN, F, 1'b1);
        clear_flag();
        cmp("R5", "ge inf,inf ordered", C_GE, P_INF, P_INF, T, 1'b0);
    endtask

    task automatic t_sticky();
        cmp("R9", "raise", C_GT, QNAN, P_ONE, F, 1'b1);
        cmp("R9", "held over clean compare", C_GE, P_TWO, P_ONE, T, 1'b1);
        @(negedge clk);
        chk("R9", "held over idle", F, 1'b0, 1'b1, 1'b0);
        clear_flag();
        chk("R9", "clear drops flag", F, 1'b0, 1'b0, 1'b0);
        run(C_GE, QNAN, P_ONE, 1'b1);
        chk("R9", "event beats clear", F, 1'b1, 1'b1, 1'b0);
        clear_flag();
    endtask

    task automatic t_bad_code();
        cmp("R9", "raise before bad code", C_GE, QNAN, P_ONE, F, 1'b1);
        run(5'h05, P_TWO, P_ONE, 1'b0);
        chk("R10", "code 05 with flag set", F, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        chk("R10", "strobe lasts one cycle", F, 1'b0, 1'b1, 1'b0);
        clear_flag();
        run(5'h00, SNAN, QNAN, 1'b0);
        chk("R10", "code 00 with nans keeps flag clear", F, 1'b1, 1'b0, 1'b1);
        run(5'h1F, P_ONE, P_ONE, 1'b0);
        chk("R10", "code 1F equal operands", F, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_idle();
        cmp("R12", "raise before idle", C_GT, SNAN, P_ONE, F, 1'b1);
        @(negedge clk);
        func = C_GE;
        op_a = P_TWO;
        op_b = P_ONE;
        @(negedge clk);
        chk("R12", "idle with valid operands", F, 1'b0, 1'b1, 1'b0);
        op_a = QNAN;
        @(negedge clk);
        chk("R12", "idle with nan operand", F, 1'b0, 1'b1, 1'b0);
        clear_flag();
        op_a = SNAN;
        @(negedge clk);
        chk("R12", "idle snan does not raise", F, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_codes();
        t_abs();
        t_zero();
        t_subnormal();
        t_quiet_eq();
        t_snan_eq();
        t_signal();
        t_sticky();
        t_bad_code();
        t_idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule